// File: doc/BRIEF.md
# Counter-Ramp ADC Sequencer

This block is the digital half of a counter-ramp analog-to-digital converter. It drives a binary code into an external resistor-ladder DAC and reads back one comparator bit that is high while the analog input still lies above the ladder voltage. As long as that bit stays high the code climbs one step at a time. When the ladder voltage crosses the input, the code stops and is held as the conversion result, and a valid flag rises.

The code only ever moves upward. If the analog input later rises above the held level, the block starts climbing again by itself until it passes the new level. If the input falls, the held code does not change, and only a reset starts a fresh ramp from zero. The comparator bit is asynchronous to the clock, so it passes through a synchronizer. Each step is then paced so that the decision to advance always sees the comparator's answer for the code currently on the ladder. The result is therefore exact, with no overshoot caused by synchronizer latency. The cost is that conversion time grows linearly with the result.

Top module: `adc_ramp_ctrl`

## Requirements
- R1: While `rst_n` is low, and right after its release, `dac_code_o` is 0, `valid_o` is 0 and `busy_o` is 1. The reset acts without waiting for a clock edge.
- R2: The code changes only by +1, and never more often than once per step period of STEP = SYNC_STAGES + 1 + SETTLE_CYC clock cycles (3 with the defaults).
- R3: `cmp_above_i` = 1 means the analog input is above the ladder output. The held result is the first code whose comparator reading is 0, i.e. one ladder step above an input lying between two codes.
- R4: A conversion from reset ends with `valid_o` rising exactly STEP*(result+1) clock edges after reset release. The code is stable while `valid_o` stays high.
- R5: At the all-ones code (2^CODE_W-1) the counter saturates and does not wrap, even with the comparator held at 1, and `valid_o` is then asserted.
- R6: If the comparator reads 1 again while a result is held, counting resumes without any external action. The first increment comes on the third clock edge after the change (defaults), `valid_o` clears on that same edge, and the ramp continues until the new level is passed.
- R7: If the analog input falls while a result is held, the code and `valid_o` stay unchanged until a reset.
- R8: `busy_o` is always the inverse of `valid_o`.
- R9: The comparator is sampled through a SYNC_STAGES-flop synchronizer, default 2. Its latency is part of the step period in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously by the system |
| cmp_above_i | input | 1 | Comparator: 1 while analog input is above the ladder output |
| dac_code_o | output | CODE_W | Code driven to the resistor-ladder DAC; conversion result when valid |
| busy_o | output | 1 | Ramp in progress |
| valid_o | output | 1 | Held code is a settled result |

## Verification
The assertions rely on the comparator depending only on the code on the ladder and on the analog level. The saturation and up-only checks also assume a reset has been seen before any clock edge. The bench models the ladder and comparator as a threshold, `code < level`, on the live output code, which places the input half a step below `level`. It changes `level` only at falling clock edges, and only between conversions or while a result is held. The stimulus sweeps every level from 0 to beyond full scale, so the saturation and one-step-above corners are reached.

// File: rtl/adc_ramp_pkg.sv
package adc_ramp_pkg;
  // Cycles between two ramp decisions: synchronizer latency, one cycle for
  // the code register to reach the ladder, plus extra analog settling.
  function automatic int unsigned step_cycles(input int unsigned sync_stages,
                                              input int unsigned settle_cyc);
    return sync_stages + 1 + settle_cyc;
  endfunction

  function automatic int unsigned cnt_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/adc_ramp_sync.sv
module adc_ramp_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] pipe_q;
  logic [STAGES-1:0] pipe_d;

  generate
    if (STAGES == 1) begin : g_single
      always_comb pipe_d = d_i;
    end else begin : g_chain
      always_comb pipe_d = {pipe_q[STAGES-2:0], d_i};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= pipe_d;
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/adc_ramp_pacer.sv
module adc_ramp_pacer #(
  parameter int unsigned STEP = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step_taken_i,
  output logic decide_o
);
  import adc_ramp_pkg::*;
  localparam int unsigned WW = cnt_width(STEP);
  localparam logic [WW-1:0] LAST = WW'(STEP - 1);

  logic [WW-1:0] wait_q, wait_d;

  always_comb begin
    wait_d = wait_q;
    if (step_taken_i)        wait_d = '0;
    else if (wait_q != LAST) wait_d = wait_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wait_q <= '0;
    else        wait_q <= wait_d;
  end

  assign decide_o = (wait_q == LAST);

  // A step may only be taken at a decision point.
  AST_STEP_AT_DECISION: assert property (@(posedge clk) disable iff (!rst_n)
    step_taken_i |-> decide_o); // R2
endmodule

// File: rtl/adc_ramp_counter.sv
module adc_ramp_counter #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc_i,
  output logic [W-1:0] code_o,
  output logic         at_max_o
);
  localparam logic [W-1:0] MAX = {W{1'b1}};

  logic [W-1:0] code_q, code_d;

  always_comb begin
    code_d = code_q;
    if (inc_i && (code_q != MAX)) code_d = code_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) code_q <= '0;
    else        code_q <= code_d;
  end

  assign code_o   = code_q;
  assign at_max_o = (code_q == MAX);

  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (code_q == MAX) |=> (code_q == MAX)); // R5
  AST_UP_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (code_q != $past(code_q)) |-> (code_q == $past(code_q) + 1'b1)); // R2
endmodule

// File: rtl/adc_ramp_ctrl.sv
module adc_ramp_ctrl #(
  parameter int unsigned CODE_W      = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned SETTLE_CYC  = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmp_above_i,
  output logic [CODE_W-1:0] dac_code_o,
  output logic              busy_o,
  output logic              valid_o
);
  import adc_ramp_pkg::*;
  localparam int unsigned STEP = step_cycles(SYNC_STAGES, SETTLE_CYC);

  logic cmp_s;
  logic decide;
  logic at_max;
  logic step_taken;
  logic valid_q, valid_d;

  adc_ramp_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(cmp_above_i), .q_o(cmp_s)
  );

  adc_ramp_pacer #(.STEP(STEP)) u_pacer (
    .clk(clk), .rst_n(rst_n), .step_taken_i(step_taken), .decide_o(decide)
  );

  adc_ramp_counter #(.W(CODE_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .inc_i(step_taken),
    .code_o(dac_code_o), .at_max_o(at_max)
  );

  // Advance only at a paced decision point, while the input is still above.
  assign step_taken = decide && cmp_s && !at_max;

  always_comb begin
    valid_d = valid_q;
    if (decide) valid_d = !step_taken;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= valid_d;
  end

  assign valid_o = valid_q;
  assign busy_o  = !valid_q;

  AST_HOLD_WHEN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_s |=> $stable(dac_code_o)); // R3
  AST_RESULT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && $past(valid_o)) |-> $stable(dac_code_o)); // R4
  AST_STEP_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (dac_code_o != $past(dac_code_o)) |-> ($past(dac_code_o) == $past(dac_code_o, 2))); // R2
  AST_RESUME_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (dac_code_o != $past(dac_code_o)) |-> !valid_o); // R6
endmodule

// File: tb/tb_adc_ramp_ctrl.sv
module tb_adc_ramp_ctrl;
  localparam int W    = 8;
  localparam int MAXC = (1 << W) - 1;
  localparam int STEP = 3;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] code;
  logic         busy, valid;
  int           lvl = 0;
  logic         cmp;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;

  always #2 clk = ~clk;

  // Ladder plus comparator: input sits half a step below lvl.
  assign cmp = (int'(code) < lvl);

  adc_ramp_ctrl #(.CODE_W(W), .SYNC_STAGES(2), .SETTLE_CYC(0)) dut (
    .clk(clk), .rst_n(rst_n), .cmp_above_i(cmp),
    .dac_code_o(code), .busy_o(busy), .valid_o(valid)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 195000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(code == 0, "R1 code in reset", int'(code), 0);
    chk(valid == 0 && busy == 1, "R1 flags in reset", int'(valid), 0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // Returns number of edges after reset release until valid rose.
  task automatic wait_valid(output int edges);
    edges = 0;
    while (!valid && edges < STEP * (MAXC + 4)) begin
      @(posedge clk); #1;
      edges++;
    end
  endtask

  task automatic convert(input int l);
    int e, exp;
    lvl = l;
    do_reset();
    wait_valid(e);
    exp = (l > MAXC) ? MAXC : l;
    chk(int'(code) == exp, (l > MAXC) ? "R5 saturated code" : "R3 result code", int'(code), exp);
    chk(e == STEP * (exp + 1), "R4 conversion time", e, STEP * (exp + 1));
    chk(busy == !valid, "R8 busy inverse", int'(busy), int'(!valid));
  endtask

  initial begin
    int e;
    lvl = 0;
    #1;
    chk(code == 0 && valid == 0 && busy == 1, "R1 power-on reset", int'(code), 0);

    // Sweep every level, including beyond full scale (R3 R4 R5 R9).
    for (int l = 0; l <= MAXC + 2; l++) convert(l);

    // Saturation: comparator stays high, no wrap after many cycles (R5).
    repeat (20) begin @(posedge clk); #1; end
    chk(int'(code) == MAXC && valid, "R5 no wrap", int'(code), MAXC);

    // Ramp pacing: mid-ramp the code equals edges/STEP (R2).
    lvl = 200;
    do_reset();
    repeat (31) begin @(posedge clk); #1; end
    chk(int'(code) == 31 / STEP, "R2 ramp rate", int'(code), 31 / STEP);
    chk(busy == 1, "R8 busy while ramping", int'(busy), 1);

    // Resume on rising input (R6).
    convert(40);
    @(negedge clk);
    lvl = 100;
    repeat (2) begin @(posedge clk); #1; end
    chk(int'(code) == 40 && valid, "R6 no step before sync", int'(code), 40);
    @(posedge clk); #1;
    chk(int'(code) == 41, "R6 first resumed step", int'(code), 41);
    chk(valid == 0, "R6 valid cleared on resume", int'(valid), 0);
    wait_valid(e);
    chk(int'(code) == 100, "R6 resumed result", int'(code), 100);

    // Falling input is ignored until reset (R7).
    @(negedge clk);
    lvl = 10;
    repeat (25) begin @(posedge clk); #1; end
    chk(int'(code) == 100, "R7 code held on fall", int'(code), 100);
    chk(valid == 1, "R7 valid held on fall", int'(valid), 1);
    convert(10);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule